// File: doc/BRIEF.md
# NAND Spare Area Packer

The packer moves out-of-band bytes between two on-chip byte RAMs. One RAM holds the flash controller's spare regions, one region per 512-byte sector, each region starting at a fixed stride. The other holds the same bytes as one contiguous out-of-band array, which is the form software expects. A transfer goes one of two ways. A gather reads the spare regions and writes the contiguous array. A scatter reads the contiguous array and writes the spare regions.

The geometry comes in with each transfer: the page size in bytes, the total out-of-band size and the spare stride. The stride is typically 16 or 64 bytes, depending on the controller generation. From these the block derives the sector count and an even per-sector share. Every sector except the last copies that share. The last sector copies whatever bytes are left over, so the copy lengths are not uniform.

A one-cycle start pulse begins a transfer and a one-cycle done pulse ends it. Both RAM ports are simple synchronous ports with one cycle of read latency. Once the per-sector share is known, one byte moves per clock.

Top module: `nand_spare_packer`

## Requirements
- R1: The sector count is page_bytes divided by 512 (page_bytes shifted right by 9). A page smaller than 512 bytes is handled as one sector.
- R2: The per-sector share L is oob_bytes divided by the sector count, rounded down, with bit 0 then forced to zero.
- R3: For every sector i other than the last, L bytes move between contiguous offset i*L+k and spare address i*stride+k, for k from 0 to L-1.
- R4: The last sector n-1 moves the oob_bytes-(n-1)*L remaining bytes between contiguous offset (n-1)*L+k and spare address (n-1)*stride+k. When L is zero, all bytes go to the last sector.
- R5: dir_scatter=0 selects gather (spare RAM read, contiguous RAM written). dir_scatter=1 selects scatter (contiguous RAM read, spare RAM written). The RAM being read is never written during that transfer.
- R6: Each RAM read has one cycle of latency. The write of a byte is presented in the cycle after its read. Bytes move one per cycle. For oob_bytes>0, done is first seen oob_bytes+12 cycles after the start edge (default OOB_W=8); for oob_bytes=0 it is seen 11 cycles after.
- R7: A transfer performs exactly oob_bytes writes. Every destination byte outside the mapped ranges keeps its old value.
- R8: done is high for exactly one cycle, busy is low while done is high, and no RAM enable is active while idle. With oob_bytes=0 the transfer ends with done and no RAM access.
- R9: A start pulse that arrives while busy is high is ignored.
- R10: The direction and geometry are sampled on the accepted start. Changes to them during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| dir_scatter | input | 1 | 0 = gather into the contiguous array, 1 = scatter into the spare regions |
| page_bytes | input | PAGE_W | Page size in bytes |
| oob_bytes | input | OOB_W | Total out-of-band bytes |
| spare_stride | input | STRIDE_W | Distance in bytes between consecutive spare regions |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| cg_addr | output | OOB_W | Contiguous RAM address |
| cg_rd_en | output | 1 | Contiguous RAM read enable |
| cg_rdata | input | 8 | Contiguous RAM read data, valid one cycle after cg_rd_en |
| cg_wr_en | output | 1 | Contiguous RAM write enable |
| cg_wdata | output | 8 | Contiguous RAM write data |
| sp_addr | output | SP_AW | Spare RAM address |
| sp_rd_en | output | 1 | Spare RAM read enable |
| sp_rdata | input | 8 | Spare RAM read data, valid one cycle after sp_rd_en |
| sp_wr_en | output | 1 | Spare RAM write enable |
| sp_wdata | output | 8 | Spare RAM write data |

## Verification
The bench goes after the cases where the last sector differs from the others:
- An odd quotient that must be rounded down to even (30 bytes over 4 sectors). A design that skips the rounding would shift every later sector by one byte.
- A share that rounds to zero (3 bytes over 4 sectors). This must send every byte to the last region; a design that got it wrong would write region 0 or would never finish.
- A non-power-of-two sector count and a page below 512 bytes. These catch a divider that assumes shifts, or a design that divides by zero.
- A zero-length transfer, and a second start with different geometry issued mid-transfer. A design that re-sampled its inputs or restarted would corrupt the untouched sentinel bytes or change the write count.

// File: rtl/spk_pkg.sv
package spk_pkg;

   localparam int BYTE_W       = 8;
   localparam int SECTOR_SHIFT = 9;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CALC  = 2'd1,
      ST_MOVE  = 2'd2,
      ST_DRAIN = 2'd3
   } spk_state_e;

endpackage

// File: rtl/spk_len_calc.sv
// Per-sector share: (oob / secs) with bit 0 cleared.
// POW2_ONLY=1 uses a shift (sector count must be a power of two),
// otherwise a restoring divider runs OOB_W cycles.
module spk_len_calc #(
   parameter int OOB_W     = 8,
   parameter int SEC_W     = 7,
   parameter bit POW2_ONLY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [OOB_W-1:0] oob,
   input  logic [SEC_W-1:0] secs,
   output logic [OOB_W-1:0] len,
   output logic             ready
);

   localparam int CNT_W = $clog2(OOB_W + 1);
   localparam int SH_W  = (SEC_W > 1) ? $clog2(SEC_W) : 1;

   if (OOB_W < 2) begin : g_bad_oob
      $error("spk_len_calc: OOB_W must be at least 2");
   end

   if (POW2_ONLY) begin : g_shift
      logic [SH_W-1:0]  sh;
      logic [OOB_W-1:0] quo;
      logic [OOB_W-1:0] len_q;
      logic             rdy_q;

      always_comb begin
         sh = '0;
         for (int k = 0; k < SEC_W; k++) begin
            if (secs[k]) sh = SH_W'(k);
         end
      end

      assign quo = oob >> sh;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_q <= '0;
            rdy_q <= 1'b0;
         end else begin
            rdy_q <= go;
            if (go) len_q <= {quo[OOB_W-1:1], 1'b0};
         end
      end

      assign len   = len_q;
      assign ready = rdy_q;
   end else begin : g_divide
      logic [SEC_W-1:0] rem_q;
      logic [OOB_W-1:0] dvd_q;
      logic [OOB_W-1:0] quo_q;
      logic [CNT_W-1:0] cnt_q;
      logic             run_q;
      logic             rdy_q;
      logic [SEC_W:0]   trial;
      logic             fits;

      assign trial = {rem_q, dvd_q[OOB_W-1]};
      assign fits  = (trial >= {1'b0, secs});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q <= '0;
            dvd_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            rdy_q <= 1'b0;
         end else begin
            rdy_q <= 1'b0;
            if (go) begin
               rem_q <= '0;
               dvd_q <= oob;
               quo_q <= '0;
               cnt_q <= CNT_W'(OOB_W);
               run_q <= 1'b1;
            end else if (run_q) begin
               if (fits) begin
                  rem_q <= SEC_W'(trial - {1'b0, secs});
                  quo_q <= {quo_q[OOB_W-2:0], 1'b1};
               end else begin
                  rem_q <= trial[SEC_W-1:0];
                  quo_q <= {quo_q[OOB_W-2:0], 1'b0};
               end
               dvd_q <= {dvd_q[OOB_W-2:0], 1'b0};
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) begin
                  run_q <= 1'b0;
                  rdy_q <= 1'b1;
               end
            end
         end
      end

      assign len   = {quo_q[OOB_W-1:1], 1'b0};
      assign ready = rdy_q;
   end

endmodule

// File: rtl/spk_walker.sv
// Walks contiguous offset and spare address in step.
module spk_walker #(
   parameter int OOB_W    = 8,
   parameter int SEC_W    = 7,
   parameter int STRIDE_W = 8,
   parameter int SP_AW    = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [OOB_W-1:0]    len,
   input  logic [OOB_W-1:0]    oob,
   input  logic [SEC_W-1:0]    secs,
   input  logic [STRIDE_W-1:0] stride,
   output logic [OOB_W-1:0]    coff,
   output logic [SP_AW-1:0]    soff,
   output logic                last_byte
);

   localparam int PROD_W = SEC_W + STRIDE_W;

   logic [SEC_W-1:0]  sec_q;
   logic [SEC_W-1:0]  sec_last;
   logic [OOB_W-1:0]  inner_q;
   logic [OOB_W-1:0]  inner_nx;
   logic [OOB_W-1:0]  coff_q;
   logic [SP_AW-1:0]  base_q;
   logic [SP_AW-1:0]  last_base;
   logic [PROD_W-1:0] prod;
   logic              sec_wrap;

   assign sec_last  = secs - 1'b1;
   assign prod      = PROD_W'(sec_last) * PROD_W'(stride);
   assign last_base = SP_AW'(prod);
   assign inner_nx  = inner_q + 1'b1;
   assign sec_wrap  = (sec_q != sec_last) && (inner_nx == len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= '0;
         inner_q <= '0;
         coff_q  <= '0;
         base_q  <= '0;
      end else if (load) begin
         coff_q  <= '0;
         inner_q <= '0;
         if (len == '0) begin
            sec_q  <= sec_last;
            base_q <= last_base;
         end else begin
            sec_q  <= '0;
            base_q <= '0;
         end
      end else if (step) begin
         coff_q <= coff_q + 1'b1;
         if (sec_wrap) begin
            sec_q   <= sec_q + 1'b1;
            base_q  <= base_q + SP_AW'(stride);
            inner_q <= '0;
         end else begin
            inner_q <= inner_nx;
         end
      end
   end

   assign coff      = coff_q;
   assign soff      = base_q + SP_AW'(inner_q);
   assign last_byte = (coff_q == oob - 1'b1);

endmodule

// File: rtl/spk_xfer.sv
// Read-then-write byte pipe between the two RAM ports.
module spk_xfer #(
   parameter int OOB_W = 8,
   parameter int SP_AW = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      issue,
   input  logic                      scatter,
   input  logic [OOB_W-1:0]          coff,
   input  logic [SP_AW-1:0]          soff,
   output logic                      pend,
   output logic [OOB_W-1:0]          cg_addr,
   output logic                      cg_rd_en,
   input  logic [spk_pkg::BYTE_W-1:0] cg_rdata,
   output logic                      cg_wr_en,
   output logic [spk_pkg::BYTE_W-1:0] cg_wdata,
   output logic [SP_AW-1:0]          sp_addr,
   output logic                      sp_rd_en,
   input  logic [spk_pkg::BYTE_W-1:0] sp_rdata,
   output logic                      sp_wr_en,
   output logic [spk_pkg::BYTE_W-1:0] sp_wdata
);

   logic             pend_q;
   logic [OOB_W-1:0] coff_q;
   logic [SP_AW-1:0] soff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         coff_q <= '0;
         soff_q <= '0;
      end else begin
         pend_q <= issue;
         coff_q <= coff;
         soff_q <= soff;
      end
   end

   assign pend     = pend_q;
   assign cg_rd_en = issue & scatter;
   assign sp_rd_en = issue & ~scatter;
   assign cg_wr_en = pend_q & ~scatter;
   assign sp_wr_en = pend_q & scatter;
   assign cg_addr  = scatter ? coff : coff_q;
   assign sp_addr  = scatter ? soff_q : soff;
   assign cg_wdata = sp_rdata;
   assign sp_wdata = cg_rdata;

endmodule

// File: rtl/nand_spare_packer.sv
module nand_spare_packer #(
   parameter int PAGE_W    = 16,
   parameter int OOB_W     = 8,
   parameter int STRIDE_W  = 8,
   parameter int SP_AW     = 10,
   parameter bit POW2_ONLY = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                dir_scatter,
   input  logic [PAGE_W-1:0]   page_bytes,
   input  logic [OOB_W-1:0]    oob_bytes,
   input  logic [STRIDE_W-1:0] spare_stride,
   output logic                busy,
   output logic                done,
   output logic [OOB_W-1:0]    cg_addr,
   output logic                cg_rd_en,
   input  logic [7:0]          cg_rdata,
   output logic                cg_wr_en,
   output logic [7:0]          cg_wdata,
   output logic [SP_AW-1:0]    sp_addr,
   output logic                sp_rd_en,
   input  logic [7:0]          sp_rdata,
   output logic                sp_wr_en,
   output logic [7:0]          sp_wdata
);
   import spk_pkg::*;

   localparam int SEC_W = PAGE_W - SECTOR_SHIFT;

   if (PAGE_W <= SECTOR_SHIFT) begin : g_bad_page
      $error("nand_spare_packer: PAGE_W must exceed 9");
   end
   if (SP_AW < OOB_W) begin : g_bad_sp
      $error("nand_spare_packer: SP_AW must be at least OOB_W");
   end

   spk_state_e          state_q;
   logic                scatter_q;
   logic [OOB_W-1:0]    oob_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [SEC_W-1:0]    secs_q;
   logic [SEC_W-1:0]    sec_raw;
   logic [SEC_W-1:0]    secs_in;
   logic                go_q;
   logic                done_q;
   logic                accept;
   logic [OOB_W-1:0]    len;
   logic                len_ready;
   logic                walk_load;
   logic                issue;
   logic [OOB_W-1:0]    coff;
   logic [SP_AW-1:0]    soff;
   logic                last_byte;
   logic                pend;

   assign sec_raw   = page_bytes[PAGE_W-1:SECTOR_SHIFT];
   assign secs_in   = (sec_raw == '0) ? SEC_W'(1) : sec_raw;
   assign accept    = (state_q == ST_IDLE) && start;
   assign walk_load = (state_q == ST_CALC) && len_ready && (oob_q != '0);
   assign issue     = (state_q == ST_MOVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         scatter_q <= 1'b0;
         oob_q     <= '0;
         stride_q  <= '0;
         secs_q    <= SEC_W'(1);
         go_q      <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         go_q   <= accept;
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  scatter_q <= dir_scatter;
                  oob_q     <= oob_bytes;
                  stride_q  <= spare_stride;
                  secs_q    <= secs_in;
                  state_q   <= ST_CALC;
               end
            end
            ST_CALC: begin
               if (len_ready) begin
                  if (oob_q == '0) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_MOVE;
                  end
               end
            end
            ST_MOVE: begin
               if (last_byte) state_q <= ST_DRAIN;
            end
            ST_DRAIN: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   spk_len_calc #(
      .OOB_W     (OOB_W),
      .SEC_W     (SEC_W),
      .POW2_ONLY (POW2_ONLY)
   ) len_i (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go_q),
      .oob   (oob_q),
      .secs  (secs_q),
      .len   (len),
      .ready (len_ready)
   );

   spk_walker #(
      .OOB_W    (OOB_W),
      .SEC_W    (SEC_W),
      .STRIDE_W (STRIDE_W),
      .SP_AW    (SP_AW)
   ) walk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (walk_load),
      .step      (issue),
      .len       (len),
      .oob       (oob_q),
      .secs      (secs_q),
      .stride    (stride_q),
      .coff      (coff),
      .soff      (soff),
      .last_byte (last_byte)
   );

   spk_xfer #(
      .OOB_W (OOB_W),
      .SP_AW (SP_AW)
   ) xfer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .scatter  (scatter_q),
      .coff     (coff),
      .soff     (soff),
      .pend     (pend),
      .cg_addr  (cg_addr),
      .cg_rd_en (cg_rd_en),
      .cg_rdata (cg_rdata),
      .cg_wr_en (cg_wr_en),
      .cg_wdata (cg_wdata),
      .sp_addr  (sp_addr),
      .sp_rd_en (sp_rd_en),
      .sp_rdata (sp_rdata),
      .sp_wr_en (sp_wr_en),
      .sp_wdata (sp_wdata)
   );

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

endmodule

// File: rtl/spk_checker.sv
module spk_checker #(
   parameter int OOB_W = 8,
   parameter int SP_AW = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [OOB_W-1:0] oob_bytes,
   input logic             busy,
   input logic             done,
   input logic [OOB_W-1:0] cg_addr,
   input logic             cg_rd_en,
   input logic             cg_wr_en,
   input logic [SP_AW-1:0] sp_addr,
   input logic             sp_rd_en,
   input logic             sp_wr_en
);

   logic [OOB_W:0]   wr_cnt;
   logic [OOB_W-1:0] oob_lat;
   logic             any_rd;
   logic             any_wr;

   assign any_rd = cg_rd_en | sp_rd_en;
   assign any_wr = cg_wr_en | sp_wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt  <= '0;
         oob_lat <= '0;
      end else if (start && !busy) begin
         wr_cnt  <= '0;
         oob_lat <= oob_bytes;
      end else if (any_wr) begin
         wr_cnt <= wr_cnt + 1'b1;
      end
   end

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(any_rd || any_wr));

   a_r6_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
      any_rd |=> any_wr);

   a_r6_wr_has_rd: assert property (@(posedge clk) disable iff (!rst_n)
      any_wr |-> $past(any_rd));

   a_r5_roles: assert property (@(posedge clk) disable iff (!rst_n)
      !(cg_rd_en && cg_wr_en) && !(sp_rd_en && sp_wr_en) && !(cg_wr_en && sp_wr_en)
      && !(cg_rd_en && sp_rd_en));

   a_r3_cg_wr_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (cg_wr_en && $past(cg_wr_en)) |-> (cg_addr == $past(cg_addr) + 1'b1));

   a_r3_cg_rd_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (cg_rd_en && $past(cg_rd_en)) |-> (cg_addr == $past(cg_addr) + 1'b1));

   a_r7_write_count: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_cnt == {1'b0, oob_lat}));

   a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy || done));

endmodule

bind nand_spare_packer spk_checker #(
   .OOB_W (OOB_W),
   .SP_AW (SP_AW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .oob_bytes (oob_bytes),
   .busy      (busy),
   .done      (done),
   .cg_addr   (cg_addr),
   .cg_rd_en  (cg_rd_en),
   .cg_wr_en  (cg_wr_en),
   .sp_addr   (sp_addr),
   .sp_rd_en  (sp_rd_en),
   .sp_wr_en  (sp_wr_en)
);

// File: tb/nand_spare_packer_tb_top.sv
module nand_spare_packer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PAGE_W     = 16;
   localparam int OOB_W      = 8;
   localparam int STRIDE_W   = 8;
   localparam int SP_AW      = 10;
   localparam int CG_N       = 1 << OOB_W;
   localparam int SP_N       = 1 << SP_AW;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic                dir_scatter = 1'b0;
   logic [PAGE_W-1:0]   page_bytes = '0;
   logic [OOB_W-1:0]    oob_bytes = '0;
   logic [STRIDE_W-1:0] spare_stride = '0;
   logic                busy, done;
   logic [OOB_W-1:0]    cg_addr;
   logic                cg_rd_en, cg_wr_en;
   logic [7:0]          cg_rdata, cg_wdata;
   logic [SP_AW-1:0]    sp_addr;
   logic                sp_rd_en, sp_wr_en;
   logic [7:0]          sp_rdata, sp_wdata;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   logic       fill_req = 1'b0;
   int         fill_seed = 0;

   logic [7:0] cg_mem [CG_N];
   logic [7:0] sp_mem [SP_N];
   logic [7:0] exp_cg [CG_N];
   logic [7:0] exp_sp [SP_N];

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_spare_packer #(
      .PAGE_W(PAGE_W), .OOB_W(OOB_W), .STRIDE_W(STRIDE_W), .SP_AW(SP_AW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_scatter(dir_scatter),
      .page_bytes(page_bytes), .oob_bytes(oob_bytes), .spare_stride(spare_stride),
      .busy(busy), .done(done),
      .cg_addr(cg_addr), .cg_rd_en(cg_rd_en), .cg_rdata(cg_rdata),
      .cg_wr_en(cg_wr_en), .cg_wdata(cg_wdata),
      .sp_addr(sp_addr), .sp_rd_en(sp_rd_en), .sp_rdata(sp_rdata),
      .sp_wr_en(sp_wr_en), .sp_wdata(sp_wdata)
   );

   function automatic logic [7:0] pat_cg(int i, int s);
      return 8'((i * 13 + s * 29 + 1) & 255);
   endfunction

   function automatic logic [7:0] pat_sp(int i, int s);
      return 8'(((i * 7) ^ (s * 53) ^ 90) & 255);
   endfunction

   // RAM models: synchronous read, one cycle latency
   always @(posedge clk) begin
      if (fill_req) begin
         for (int i = 0; i < CG_N; i++) cg_mem[i] <= pat_cg(i, fill_seed);
         for (int i = 0; i < SP_N; i++) sp_mem[i] <= pat_sp(i, fill_seed);
      end else begin
         if (cg_rd_en) cg_rdata <= cg_mem[cg_addr];
         if (cg_wr_en) cg_mem[cg_addr] <= cg_wdata;
         if (sp_rd_en) sp_rdata <= sp_mem[sp_addr];
         if (sp_wr_en) sp_mem[sp_addr] <= sp_wdata;
      end
      if (cg_wr_en || sp_wr_en) wr_cnt <= wr_cnt + 1;
   end

   task automatic check(input string req, input string what, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Reference mapping built from the requirements
   task automatic build_expected(input bit scat, input int page, input int oob,
                                 input int stride, input int seed);
      int n, l, s, sa;
      for (int i = 0; i < CG_N; i++) exp_cg[i] = pat_cg(i, seed);
      for (int i = 0; i < SP_N; i++) exp_sp[i] = pat_sp(i, seed);
      n = page >> 9;
      if (n == 0) n = 1;
      l = (oob / n) & ~1;
      for (int j = 0; j < oob; j++) begin
         if (l == 0) s = n - 1;
         else begin
            s = j / l;
            if (s > n - 1) s = n - 1;
         end
         sa = (s * stride + (j - s * l)) % SP_N;
         if (scat) exp_sp[sa] = pat_cg(j, seed);
         else      exp_cg[j]  = pat_sp(sa, seed);
      end
   endtask

   task automatic run_xfer(input string req, input bit scat, input int page,
                           input int oob, input int stride, input int seed,
                           input bit disturb);
      int cyc, bad_cg, bad_sp, exp_cyc;
      bit seen;
      @(negedge clk);
      fill_seed = seed;
      fill_req  = 1'b1;
      @(negedge clk);
      fill_req  = 1'b0;
      build_expected(scat, page, oob, stride, seed);
      wr_cnt       = 0;
      dir_scatter  = scat;
      page_bytes   = PAGE_W'(page);
      oob_bytes    = OOB_W'(oob);
      spare_stride = STRIDE_W'(stride);
      start        = 1'b1;
      cyc  = 0;
      seen = 1'b0;
      while (!seen && cyc < 2000) begin
         @(negedge clk);
         cyc++;
         start = 1'b0;
         if (disturb && cyc == 3) begin
            // R9 / R10: second start and new inputs during the transfer
            start        = 1'b1;
            dir_scatter  = ~scat;
            page_bytes   = PAGE_W'(512);
            oob_bytes    = OOB_W'(5);
            spare_stride = STRIDE_W'(64);
         end
         if (disturb && cyc == 20) begin
            start = 1'b1;
         end
         if (done) seen = 1'b1;
      end
      start = 1'b0;
      check(req, "done reached", int'(seen), 1);
      check("R8", "busy low at done", int'(busy), 0);
      exp_cyc = (oob == 0) ? 11 : oob + 12;
      check("R6", "cycles to done", cyc, exp_cyc);
      @(negedge clk);
      check("R8", "done one cycle", int'(done), 0);
      check("R7", "write count", wr_cnt, oob);
      bad_cg = 0;
      bad_sp = 0;
      for (int i = 0; i < CG_N; i++) if (cg_mem[i] !== exp_cg[i]) bad_cg++;
      for (int i = 0; i < SP_N; i++) if (sp_mem[i] !== exp_sp[i]) bad_sp++;
      check(req, "contiguous RAM mismatches", bad_cg, 0);
      check(req, "spare RAM mismatches", bad_sp, 0);
      dir_scatter  = 1'b0;
      page_bytes   = '0;
      oob_bytes    = '0;
      spare_stride = '0;
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R8", "reset busy", int'(busy), 0);
      check("R8", "reset done", int'(done), 0);
      check("R8", "reset enables", int'(cg_rd_en | cg_wr_en | sp_rd_en | sp_wr_en), 0);
   endtask

   // R3: uniform split, gather, stride 16
   task automatic test_gather_uniform();
      run_xfer("R3", 1'b0, 2048, 64, 16, 1, 1'b0);
   endtask

   // R5: scatter with stride 64
   task automatic test_scatter_wide();
      run_xfer("R5", 1'b1, 2048, 64, 64, 2, 1'b0);
   endtask

   // R2: odd quotient rounded to even, last sector longer (R4)
   task automatic test_odd_share();
      run_xfer("R2", 1'b0, 2048, 30, 16, 3, 1'b0);
      run_xfer("R4", 1'b1, 4096, 218, 64, 4, 1'b0);
   endtask

   // R1: non power of two sector count, and sub-512 page
   task automatic test_sector_count();
      run_xfer("R1", 1'b1, 1536, 50, 16, 5, 1'b0);
      run_xfer("R1", 1'b0, 256, 16, 16, 6, 1'b0);
      run_xfer("R1", 1'b1, 512, 16, 64, 7, 1'b0);
   endtask

   // R4: share rounds to zero, all bytes land in the last region
   task automatic test_zero_share();
      run_xfer("R4", 1'b0, 2048, 3, 16, 8, 1'b0);
      run_xfer("R4", 1'b1, 2048, 3, 16, 9, 1'b0);
   endtask

   // R8: empty transfer
   task automatic test_empty();
      run_xfer("R8", 1'b1, 2048, 0, 16, 10, 1'b0);
   endtask

   // R9 and R10: start while busy and input changes ignored
   task automatic test_busy_start();
      run_xfer("R9", 1'b0, 2048, 64, 16, 11, 1'b1);
      run_xfer("R10", 1'b1, 1536, 40, 16, 12, 1'b1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_gather_uniform();
      test_scatter_wide();
      test_odd_share();
      test_sector_count();
      test_zero_share();
      test_empty();
      test_busy_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule